// File: doc/BRIEF.md
# Dual-Channel Interrupt Combiner

This block folds the interrupt requests of two storage channels into a single level-sensitive interrupt line. A shared byte-wide mode register records, for each channel, a pending flag that tracks the channel's request level and a block flag set by software. The interrupt output is raised whenever any channel is pending and not blocked.

Software reaches the block through a simple byte port. The address space is split into one 8-byte slice per channel. The mode register appears at offset 1 of every slice. Software can change only the block flags. The pending flags follow the hardware request lines and cannot be written.

Offset 3 of each slice holds a plain 8-bit timing byte for that channel. The block stores these bytes and does not interpret them. The interrupt output is registered, so it is free of glitches and settles one clock after a request or mask change.

Top module: `irq_combiner`

## Requirements
- R1: After a synchronous active-low reset, irq_out is low and the mode register and both timing bytes read 0x00.
- R2: Mode register bit 2 holds channel 0's request level and bit 3 holds channel 1's. Each bit takes the value of chan_req at a clock edge and shows it from then on.
- R3: At each clock edge, irq_out is loaded with (chan_req[0] AND NOT block0) OR (chan_req[1] AND NOT block1). Block0 is mode bit 4 and block1 is mode bit 5, using their values after any write at that edge.
- R4: A write to the mode register loads bits 4 and 5 from bus_wdata[4] and bus_wdata[5]. The pending bits are unaffected by the written data.
- R5: The mode register reads at address 1 (offset 1 of slice 0) and at address 9 (offset 1 of slice 1). A write at either address reaches the same register.
- R6: Address 3 holds an 8-bit read/write timing byte for channel 0, and address 11 holds one for channel 1. All 8 bits of each are writable, and writing one leaves the other unchanged.
- R7: Mode register bits 0, 1, 6 and 7 always read as zero, whatever value is written.
- R8: A mask write takes effect on irq_out at the same clock edge that captures it. A pending request is therefore unmasked or masked on irq_out one clock after the write.
- R9: Every other address (offsets 0, 2, 4 to 7 of either slice) reads 0x00. Writes to those addresses change no register and do not change irq_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_req | input | 2 | Request level from each channel |
| bus_addr | input | 4 | Byte address: bit 3 selects the slice, bits 2:0 the offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Combined, registered interrupt level |

## Verification
The combining function is exercised with all four request combinations under each of the four mask settings. This separates an output that ignores the mask from one that applies a channel's block to the wrong channel. Mask writes carry ones in every bit, which exposes any leak into the pending or reserved bits. Requests are held high while writing, which shows whether the one-clock latency of a mask change is kept. The two timing bytes and the unused offsets are written with distinct patterns, so an address decode that aliases the slices shows up at the ports.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the interrupt combiner.
// Assumes byte-wide registers and one 8-byte address slice per channel.
package irqc_pkg;
    localparam int SLICE_BYTES = 8;
    localparam int OFS_W       = $clog2(SLICE_BYTES);
    localparam int MODE_OFS    = 1;
    localparam int TIME_OFS    = 3;
    localparam int PEND_LSB    = 2;
endpackage

// File: rtl/irqc_addr_dec.sv
// Address decoder: turns a byte address into register selects and write enables.
// Assumes the upper address bits index the channel slice.
module irqc_addr_dec
    import irqc_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW    = OFS_W + CH_W
) (
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    output logic              mode_sel,
    output logic              mode_we,
    output logic [NUM_CH-1:0] tim_sel,
    output logic [NUM_CH-1:0] tim_we
);
    logic [OFS_W-1:0] ofs;
    logic [CH_W-1:0]  slice;

    assign ofs   = addr[OFS_W-1:0];
    assign slice = addr[AW-1:OFS_W];

    // Mode register is visible at the same offset in every slice.
    always_comb begin
        mode_sel = (ofs == OFS_W'(MODE_OFS));
        mode_we  = mode_sel & wr;
    end

    // One timing byte per slice.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_tsel
        always_comb begin
            tim_sel[c] = (ofs == OFS_W'(TIME_OFS)) && (slice == CH_W'(c));
            tim_we[c]  = tim_sel[c] & wr;
        end
    end
endmodule

// File: rtl/irqc_mode_flags.sv
// Mode flags: pending bits follow the request lines, block bits are written
// by software, and the combined interrupt is registered.
// Assumes requests are already synchronous to clk.
module irqc_mode_flags #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic              blk_we,
    input  logic [NUM_CH-1:0] blk_wdata,
    output logic [NUM_CH-1:0] pend_q,
    output logic [NUM_CH-1:0] blk_q,
    output logic              irq_q
);
    logic [NUM_CH-1:0] blk_nxt;

    // Next value of the block flags, so a mask write acts at the same edge.
    always_comb blk_nxt = blk_we ? blk_wdata : blk_q;

    // Register the flags and the combined interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            blk_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= req;
            blk_q  <= blk_nxt;
            irq_q  <= |(req & ~blk_nxt);
        end
    end
endmodule

// File: rtl/irqc_timing_bank.sv
// Timing bank: one plain read/write byte per channel, not interpreted here.
// Assumes one-hot write enables.
module irqc_timing_bank #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              we,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_CH-1:0][DATA_W-1:0]  tim_q
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
        // Store the channel's timing byte.
        always_ff @(posedge clk) begin
            if (!rst_n)     tim_q[c] <= '0;
            else if (we[c]) tim_q[c] <= wdata;
        end
    end
endmodule

// File: rtl/irq_combiner.sv
// Top: dual-channel interrupt combiner with per-channel block flags and
// timing bytes behind a byte port. Assumes a two-channel map (mode bits 2..5).
module irq_combiner
    import irqc_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW    = OFS_W + CH_W,
    localparam int BLK_LSB = PEND_LSB + NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    logic                          mode_sel;
    logic                          mode_we;
    logic [NUM_CH-1:0]             tim_sel;
    logic [NUM_CH-1:0]             tim_we;
    logic [NUM_CH-1:0]             pend_q;
    logic [NUM_CH-1:0]             blk_q;
    logic [NUM_CH-1:0][DATA_W-1:0] tim_q;
    logic [DATA_W-1:0]             mode_rd;

    irqc_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .mode_sel (mode_sel),
        .mode_we  (mode_we),
        .tim_sel  (tim_sel),
        .tim_we   (tim_we)
    );

    irqc_mode_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (chan_req),
        .blk_we    (mode_we),
        .blk_wdata (bus_wdata[BLK_LSB +: NUM_CH]),
        .pend_q    (pend_q),
        .blk_q     (blk_q),
        .irq_q     (irq_out)
    );

    irqc_timing_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_tim (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tim_we),
        .wdata (bus_wdata),
        .tim_q (tim_q)
    );

    // Assemble the mode byte; the unused bits stay zero.
    always_comb begin
        mode_rd = '0;
        mode_rd[PEND_LSB +: NUM_CH] = pend_q;
        mode_rd[BLK_LSB  +: NUM_CH] = blk_q;
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (mode_sel) bus_rdata = mode_rd;
        for (int c = 0; c < NUM_CH; c++)
            if (tim_sel[c]) bus_rdata = tim_q[c];
    end
endmodule

// File: rtl/irq_combiner_chk.sv
// Checker for irq_combiner: temporal properties over ports and flag state.
module irq_combiner_chk #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8,
    parameter int AW     = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CH-1:0]             chan_req,
    input logic [AW-1:0]                 bus_addr,
    input logic                          bus_wr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic                          irq_out,
    input logic [NUM_CH-1:0]             pend_q,
    input logic [NUM_CH-1:0]             blk_q,
    input logic [NUM_CH-1:0][DATA_W-1:0] tim_q
);
    // Pending flags copy the previous request levels.
    assert_pend_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(chan_req));

    // Output is the unblocked OR of the requests seen at the last edge.
    assert_irq_combine_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_out == |($past(chan_req) & ~blk_q));

    // Block flags change only through a mode write (offset 1).
    assert_blk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(bus_wr) && $past(bus_addr[2:0]) == 3'd1))
        |-> $stable(blk_q));

    // Reserved bits of the mode byte read as zero.
    assert_mode_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[2:0] == 3'd1) |-> (bus_rdata[1:0] == 2'b00 && bus_rdata[7:6] == 2'b00));

    // Timing bytes hold when no write hits offset 3.
    assert_tim_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(bus_wr) && $past(bus_addr[2:0]) == 3'd3))
        |-> $stable(tim_q));
endmodule

bind irq_combiner irq_combiner_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .AW(AW)) u_chk (.*);

// File: tb/irq_combiner_test.sv
// Directed bench for irq_combiner: one task per scenario.
module irq_combiner_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] chan_req;
    logic [3:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int checks = 0;
    int errors = 0;
    logic [1:0] m_blk;

    always #5 clk = ~clk;

    irq_combiner uut (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [3:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    function automatic logic [7:0] mode_val(logic [1:0] p, logic [1:0] b);
        return {2'b00, b, p, 2'b00};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; chan_req = 2'b11; bus_wr = 1'b0; bus_addr = 4'd0; bus_wdata = 8'h00;
        step(); step();
        chan_req = 2'b00;
        rst_n = 1'b1;
        m_blk = 2'b00;
        check("R1 irq", {7'd0, irq_out}, 8'h00);
        rd_check("R1 mode", 4'd1, 8'h00);
        rd_check("R1 tim0", 4'd3, 8'h00);
        rd_check("R1 tim1", 4'd11, 8'h00);
    endtask

    task automatic t_combine();
        for (int b = 0; b < 4; b++) begin
            wr(4'd1, {2'b00, 2'(b), 4'b0000});
            m_blk = 2'(b);
            for (int r = 0; r < 4; r++) begin
                chan_req = 2'(r);
                step();
                check("R3 irq", {7'd0, irq_out}, {7'd0, |(2'(r) & ~m_blk)});
                rd_check("R2 pend", 4'd1, mode_val(2'(r), m_blk));
            end
        end
    endtask

    task automatic t_mask_write();
        chan_req = 2'b01;
        wr(4'd1, 8'h00); m_blk = 2'b00;
        check("R8 unmasked", {7'd0, irq_out}, 8'h01);
        wr(4'd1, 8'hFF); m_blk = 2'b11;
        check("R8 masked next clock", {7'd0, irq_out}, 8'h00);
        rd_check("R4 R7 mode", 4'd1, mode_val(2'b01, 2'b11));
        chan_req = 2'b00;
        wr(4'd1, 8'hCF); m_blk = 2'b00;
        rd_check("R4 pend not writable", 4'd1, 8'h00);
        rd_check("R7 reserved zero", 4'd1, 8'h00);
    endtask

    task automatic t_alias();
        chan_req = 2'b10;
        wr(4'd9, 8'h20); m_blk = 2'b10;
        check("R5 write via slice1", {7'd0, irq_out}, 8'h00);
        rd_check("R5 read slice0", 4'd1, mode_val(2'b10, 2'b10));
        rd_check("R5 read slice1", 4'd9, mode_val(2'b10, 2'b10));
        wr(4'd9, 8'h10); m_blk = 2'b01;
        check("R5 unblock ch1", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_timing();
        wr(4'd3, 8'hA5);
        wr(4'd11, 8'h3C);
        rd_check("R6 tim0", 4'd3, 8'hA5);
        rd_check("R6 tim1", 4'd11, 8'h3C);
        wr(4'd3, 8'hFF);
        rd_check("R6 tim0 full", 4'd3, 8'hFF);
        rd_check("R6 tim1 kept", 4'd11, 8'h3C);
    endtask

    task automatic t_unused();
        chan_req = 2'b01;
        wr(4'd1, 8'h00); m_blk = 2'b00;
        for (int a = 0; a < 16; a++) begin
            if (a[2:0] != 3'd1 && a[2:0] != 3'd3) wr(4'(a), 8'hFF);
        end
        check("R9 irq kept", {7'd0, irq_out}, 8'h01);
        rd_check("R9 mode kept", 4'd1, mode_val(2'b01, 2'b00));
        rd_check("R9 tim0 kept", 4'd3, 8'hFF);
        rd_check("R9 tim1 kept", 4'd11, 8'h3C);
        rd_check("R9 offset0", 4'd0, 8'h00);
        rd_check("R9 offset6", 4'd14, 8'h00);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_combine();
                t_mask_write();
                t_alias();
                t_timing();
                t_unused();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule